// File: doc/BRIEF.md
# Serial Display Register Writer

This block writes 16-bit values into indexed registers of a display controller over a three-wire serial link made of an active-low chip-select, a serial clock and a data line. A client hands over an 8-bit register index and a 16-bit value through a valid/ready handshake. The block then performs the write as two separate chip-select frames. The first frame names the register. The second frame carries the value. Each frame begins with a device identification byte, and one bit in that byte tells the controller which of the two frames it is receiving.

Every step of the serial waveform lasts one phase interval, and the `PHASE_CLKS` parameter sets that interval in system clocks. The steps are: the settle time after chip-select falls, the clock-low time, the data setup time, the clock-high time, and the hold time before chip-select rises. For each bit, the clock falls first. One phase later the data line moves to the next bit, most significant bit first, and one phase after that the clock rises. The receiver samples on that rising edge. While a write is in progress, `busy` is high and `reqReady` is low. A one-cycle `done` pulse marks the end of the data frame.

Top module: `lcd_reg_writer`

## Requirements
- R1: After reset and whenever no write is in progress, `csN` and `sclk` are high, `reqReady` is high, and `busy` and `done` are low.
- R2: A request is accepted at a rising clock edge where both `reqValid` and `reqReady` are high. From the next cycle, `busy` is high and `reqReady` is low until the write ends.
- R3: Each accepted write produces exactly two chip-select frames (`csN` low). Each frame contains exactly 24 rising edges of `sclk`.
- R4: In the first frame, the bits on `sdo` at the 24 rising `sclk` edges, taken most significant bit first, form the bytes 0x74, 0x00 and the register index, in that order.
- R5: In the second frame the bytes are 0x76 (the ID with its register-select bit, value 0x02, set), then value[15:8], then value[7:0]. Bit 0 of each ID byte, the direction bit, is 0.
- R6: `sdo` changes only while `sclk` is low. `sclk` stays low for exactly 2*PHASE_CLKS cycles before each rising edge: one phase with the old bit, one phase with the new bit. It then stays high for PHASE_CLKS cycles before the next fall or the end of the frame.
- R7: `csN` falls exactly PHASE_CLKS cycles before the first falling edge of `sclk` in a frame. `csN` rises exactly PHASE_CLKS cycles after the last rising edge. `sclk` is high whenever `csN` changes.
- R8: Between the two frames of one write, `csN` stays high for exactly PHASE_CLKS cycles.
- R9: `busy` is high for exactly 148*PHASE_CLKS cycles per write. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R10: Asserting `reqValid` while `busy` is high has no effect. The frames of the running write are unchanged, and no further write follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Block can take a request this cycle |
| reqIndex | input | 8 | Register index to write |
| reqValue | input | 16 | Value to write |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse after the data frame ends |
| csN | output | 1 | Active-low chip-select to the display controller |
| sclk | output | 1 | Serial clock; the receiver samples on its rising edge |
| sdo | output | 1 | Serial data, most significant bit first |

## Verification
A bit counter that is off by one makes a frame carry 23 or 25 rising clock edges. It also moves every later byte, so the faulty frame itself shows the fault before `csN` rises. A sequencer that loses track of which frame it is in either sends a third frame or ends after one, and `busy` then stays high for the wrong number of cycles. A phase counter or a strobe that fires in the wrong phase shortens a clock-low, setup, lead, trail or gap window, or moves `sdo` while `sclk` is high. Each of these shows up at the very next edge of `sclk` or `csN`.

// File: rtl/lcd_reg_writer_pkg.sv
package lcd_reg_writer_pkg;

  localparam int BYTE_BITS   = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_BITS  = BYTE_BITS * FRAME_BYTES;

  // ID byte bit meanings
  localparam logic [7:0] REG_SEL_MASK = 8'h02;
  localparam logic [7:0] DIR_MASK     = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_SETUP,
    ST_HIGH,
    ST_TRAIL
  } wrState_t;

  typedef struct packed {
    logic loadIdx;
    logic loadData;
    logic shiftOut;
    logic csOn;
    logic csOff;
    logic clkLow;
    logic clkHigh;
  } dpStrobe_t;

endpackage

// File: rtl/lcd_reg_writer_tick.sv
module lcd_reg_writer_tick #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);

  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

  generate
    if (PHASE_CLKS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt;

      assign tick = run && (cnt == CW'(PHASE_CLKS - 1));

      always_ff @(posedge clk) begin
        if (!rstN)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      // R6: a phase never runs past its length
      p_phase_len_r6: assert property (@(posedge clk) disable iff (!rstN)
        cnt <= CW'(PHASE_CLKS - 1));
    end
  endgenerate

endmodule

// File: rtl/lcd_reg_writer_ctrl.sv
module lcd_reg_writer_ctrl
  import lcd_reg_writer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      tick,
  output logic      reqReady,
  output logic      busy,
  output logic      done,
  output logic      run,
  output dpStrobe_t strb
);

  localparam int BCW = $clog2(FRAME_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

  wrState_t       state, stNext;
  logic           isDataFrame, frameNext;
  logic [BCW-1:0] bitCnt, cntNext;
  logic           doneNext;

  assign reqReady = (state == ST_IDLE);
  assign busy     = !reqReady;
  assign run      = busy;

  always_comb begin
    strb      = '0;
    stNext    = state;
    frameNext = isDataFrame;
    cntNext   = bitCnt;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stNext       = ST_LEAD;
        frameNext    = 1'b0;
        strb.loadIdx = 1'b1;
        strb.csOn    = 1'b1;
      end
      ST_LEAD: if (tick) begin
        stNext      = ST_LOW;
        cntNext     = '0;
        strb.clkLow = 1'b1;
      end
      ST_LOW: if (tick) begin
        stNext        = ST_SETUP;
        strb.shiftOut = 1'b1;
      end
      ST_SETUP: if (tick) begin
        stNext       = ST_HIGH;
        strb.clkHigh = 1'b1;
      end
      ST_HIGH: if (tick) begin
        if (bitCnt == LAST_BIT) begin
          stNext     = ST_TRAIL;
          strb.csOff = 1'b1;
        end else begin
          stNext      = ST_LOW;
          cntNext     = bitCnt + 1'b1;
          strb.clkLow = 1'b1;
        end
      end
      ST_TRAIL: if (tick) begin
        if (!isDataFrame) begin
          stNext        = ST_LEAD;
          frameNext     = 1'b1;
          strb.loadData = 1'b1;
          strb.csOn     = 1'b1;
        end else begin
          stNext   = ST_IDLE;
          doneNext = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      isDataFrame <= 1'b0;
      bitCnt      <= '0;
      done        <= 1'b0;
    end else begin
      state       <= stNext;
      isDataFrame <= frameNext;
      bitCnt      <= cntNext;
      done        <= doneNext;
    end
  end

  // R2: an accepted request makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> busy && !reqReady);

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done only appears once the block is idle again
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady && $past(busy));

endmodule

// File: rtl/lcd_reg_writer_dp.sv
module lcd_reg_writer_dp
  import lcd_reg_writer_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h74
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [7:0]  reqIndex,
  input  logic [15:0] reqValue,
  output logic        csN,
  output logic        sclk,
  output logic        sdo
);

  localparam logic [7:0] ID_INDEX = DEV_ID & ~(REG_SEL_MASK | DIR_MASK);
  localparam logic [7:0] ID_DATA  = (DEV_ID | REG_SEL_MASK) & ~DIR_MASK;

  logic [FRAME_BITS-1:0] shReg;
  logic [15:0]           valHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      valHold <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
      sdo     <= 1'b0;
    end else begin
      if (strb.loadIdx) begin
        shReg   <= {ID_INDEX, 8'h00, reqIndex};
        valHold <= reqValue;
      end else if (strb.loadData) begin
        shReg <= {ID_DATA, valHold};
      end else if (strb.shiftOut) begin
        shReg <= {shReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.shiftOut) sdo  <= shReg[FRAME_BITS-1];
      if (strb.csOn)     csN  <= 1'b0;
      else if (strb.csOff) csN <= 1'b1;
      if (strb.clkLow)   sclk <= 1'b0;
      else if (strb.clkHigh) sclk <= 1'b1;
    end
  end

  // R6: data is held while the serial clock is high
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    sclk && $past(sclk) |-> $stable(sdo));

  // R7: chip-select only moves while the serial clock is high
  p_cs_rise_clk_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> sclk);
  p_cs_fall_clk_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> sclk);

endmodule

// File: rtl/lcd_reg_writer.sv
module lcd_reg_writer
  import lcd_reg_writer_pkg::*;
#(
  parameter int         PHASE_CLKS = 4,
  parameter logic [7:0] DEV_ID     = 8'h74
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [7:0]  reqIndex,
  input  logic [15:0] reqValue,
  output logic        busy,
  output logic        done,
  output logic        csN,
  output logic        sclk,
  output logic        sdo
);

  logic      tick;
  logic      run;
  dpStrobe_t strb;

  lcd_reg_writer_tick #(.PHASE_CLKS(PHASE_CLKS)) u_tick (
    .clk  (clk),
    .rstN (rstN),
    .run  (run),
    .tick (tick)
  );

  lcd_reg_writer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tick     (tick),
    .reqReady (reqReady),
    .busy     (busy),
    .done     (done),
    .run      (run),
    .strb     (strb)
  );

  lcd_reg_writer_dp #(.DEV_ID(DEV_ID)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqIndex (reqIndex),
    .reqValue (reqValue),
    .csN      (csN),
    .sclk     (sclk),
    .sdo      (sdo)
  );

  // R1: the serial lines rest high whenever the block is idle
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN && sclk);

endmodule

// File: tb/tb_lcd_reg_writer.sv
module tb_lcd_reg_writer;

  localparam int P = 4;
  localparam int WRITE_CYCLES = 148 * P;
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h07, 16'h0000}, {8'h3c, 16'h1234}, {8'hff, 16'hffff},
    {8'h00, 16'h8001}, {8'ha5, 16'h5a3c}, {8'h80, 16'h0100}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqIndex = '0;
  logic [15:0] reqValue = '0;
  logic reqReady, busy, done, csN, sclk, sdo;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lcd_reg_writer #(.PHASE_CLKS(P)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIndex(reqIndex), .reqValue(reqValue), .busy(busy), .done(done),
    .csN(csN), .sclk(sclk), .sdo(sdo)
  );

  // port monitor
  logic prevCs = 1'b1, prevSclk = 1'b1, prevSdo = 1'b0;
  logic [23:0] shiftCap;
  logic [23:0] frames [4];
  int frameBits [4];
  int frameCount, bitsSeen, lowRun, highRun, leadCnt, gapRun;
  int sdoBad, lowBad, leadBad, trailBad, gapBad, busyCnt, doneCnt;

  task automatic clearMon();
    frameCount = 0; bitsSeen = 0; shiftCap = '0; lowRun = 0; highRun = 0;
    leadCnt = 0; gapRun = 0; sdoBad = 0; lowBad = 0; leadBad = 0;
    trailBad = 0; gapBad = 0; busyCnt = 0; doneCnt = 0;
    for (int i = 0; i < 4; i++) begin frames[i] = '0; frameBits[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (prevSclk && sclk && sdo != prevSdo) sdoBad++;
      if (prevCs && !csN) begin
        if (frameCount == 1 && gapRun != P) gapBad++;
        bitsSeen = 0; shiftCap = '0; leadCnt = 1;
      end else if (!prevCs && csN) begin
        if (highRun != P) trailBad++;
        if (frameCount < 4) begin
          frames[frameCount] = shiftCap;
          frameBits[frameCount] = bitsSeen;
        end
        frameCount++;
        gapRun = 1;
      end else if (csN) begin
        gapRun++;
      end else if (sclk && bitsSeen == 0 && prevSclk) begin
        leadCnt++;
      end
      if (prevSclk && !sclk) begin
        if (bitsSeen == 0 && leadCnt != P) leadBad++;
        lowRun = 1;
      end else if (!prevSclk && sclk) begin
        if (lowRun != 2 * P) lowBad++;
        shiftCap = {shiftCap[22:0], sdo};
        bitsSeen++;
        highRun = 1;
      end else if (sclk) begin
        highRun++;
      end else begin
        lowRun++;
      end
      if (busy) busyCnt++;
      if (done) doneCnt++;
    end
    prevCs = csN; prevSclk = sclk; prevSdo = sdo;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] idx, input logic [15:0] val);
    @(negedge clk); #1;
    clearMon();
    reqIndex = idx; reqValue = val; reqValid = 1'b1;
    @(negedge clk); #1;
    reqValid = 1'b0;
    check(busy && !reqReady, "R2 busy after accept", {busy, reqReady}, 2'b10);
  endtask

  task automatic finishAndCheck(input logic [7:0] idx, input logic [15:0] val);
    int guard = 0;
    while (!done && guard < 4 * WRITE_CYCLES) begin
      @(negedge clk); #1;
      guard++;
    end
    check(frameCount == 2, "R3 frame count", frameCount, 2);
    check(frameBits[0] == 24 && frameBits[1] == 24, "R3 bits per frame",
          {frameBits[0][15:0], frameBits[1][15:0]}, {16'd24, 16'd24});
    check(frames[0] == {8'h74, 8'h00, idx}, "R4 index frame", frames[0], {8'h74, 8'h00, idx});
    check(frames[1] == {8'h76, val}, "R5 data frame", frames[1], {8'h76, val});
    check(sdoBad == 0 && lowBad == 0, "R6 bit timing", {sdoBad[15:0], lowBad[15:0]}, 0);
    check(leadBad == 0 && trailBad == 0, "R7 cs lead/trail", {leadBad[15:0], trailBad[15:0]}, 0);
    check(gapBad == 0, "R8 inter-frame gap", gapBad, 0);
    check(busyCnt == WRITE_CYCLES, "R9 busy length", busyCnt, WRITE_CYCLES);
    check(doneCnt == 1 && !busy, "R9 done pulse", doneCnt, 1);
    @(negedge clk); #1;
    check(csN && sclk && reqReady && !done, "R1 idle after write",
          {csN, sclk, reqReady, done}, 4'b1110);
  endtask

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    #1;
    check(csN && sclk && reqReady && !busy && !done, "R1 reset state",
          {csN, sclk, reqReady, busy, done}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(csN && sclk && reqReady && !busy && !done, "R1 idle after reset",
          {csN, sclk, reqReady, busy, done}, 5'b11100);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v][23:16], VEC[v][15:0]);
      finishAndCheck(VEC[v][23:16], VEC[v][15:0]);
    end

    // R10: requests while busy are ignored
    launch(8'h5e, 16'hc3a1);
    begin
      int readyBad = 0;
      reqIndex = 8'h99; reqValue = 16'h7777; reqValid = 1'b1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); #1;
        if (reqReady) readyBad++;
      end
      reqValid = 1'b0;
      check(readyBad == 0, "R2 ready low while busy", readyBad, 0);
    end
    finishAndCheck(8'h5e, 16'hc3a1);
    repeat (20) @(negedge clk);
    #1;
    check(frameCount == 2 && !busy, "R10 no extra write", {frameCount[15:0], 15'd0, busy}, {16'd2, 16'd0});

    // idle with no request stays idle (R2)
    clearMon();
    repeat (30) @(negedge clk);
    #1;
    check(busyCnt == 0 && frameCount == 0, "R2 no request no activity", busyCnt, 0);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule